// File: doc/BRIEF.md
# Two-Bank Pin Interrupt-on-Change Unit

This block holds the interrupt logic for sixteen general-purpose pins split into two banks of eight. Each pin input passes through a synchronizer. The block then compares the pin either with its own value one clock earlier (change mode) or with a programmed reference bit (compare mode). An enabled pin that meets its condition latches a flag in its bank and captures the whole bank's pin state. Each bank drives one interrupt line.

A host programs the block through a flat register port with a 4-bit address and 16-bit data. Register addresses: 0x2 enable mask, 0x3 reference value, 0x4 mode select (1 means compare mode), 0x5 configuration byte, 0x7 flags, 0x8 capture, 0x9 synchronized pin state. A pending interrupt is cleared by a read of the pin-state register, or by a read of the capture register if the configuration selects that. The configuration byte also sets how the interrupt lines are driven: polarity, open-drain, and merging the two banks onto both lines.

Top module: `gpx_irq_unit`

## Requirements
- R1: A pin whose enable bit (register 0x2) is 0 never sets a flag bit, whatever its input does.
- R2: With its mode bit (register 0x4) at 0, an enabled pin flags on any change of its synchronized level.
- R3: With its mode bit at 1, an enabled pin flags while its level differs from its reference bit (register 0x3). If the mismatch is still present after a clear, the pin flags again one clock later. A change to the reference level does not flag.
- R4: Flag bits 7:0 belong to bank A and bits 15:8 to bank B. At most one flag bit per bank is set: the lowest-numbered triggering pin wins. The two banks flag independently.
- R5: When a bank flags, its capture byte (register 0x8) takes that bank's pin state. While the bank's flag is pending, further pin activity changes neither its flag nor its capture byte.
- R6: With configuration bit 0 at 0, a read of register 0x9 clears both banks' flags. A read of register 0x8 does not clear them.
- R7: With configuration bit 0 at 1, a read of register 0x8 clears the flags. A read of register 0x9 does not clear them.
- R8: With configuration bit 1 at 0, an interrupt line is driven low while active and high while idle. With bit 1 at 1, the line is driven high while active.
- R9: With configuration bit 2 at 1, each line is open-drain. The output value is always 0, and the output enable is 1 only while the line is active. Bit 1 has no effect in this mode.
- R10: With configuration bit 6 at 1, either bank's flag activates both lines. With bit 6 at 0, line 0 follows bank A and line 1 follows bank B.
- R11: Every register reads 0 after reset. Writes to 0x7, 0x8 and 0x9 are ignored. Unmapped addresses read 0. The configuration register holds 8 bits.
- R12: A pin edge applied between clocks sets its flag at the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 16 | Asynchronous pin levels, bank A in bits 7:0 |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read; triggers clear side effects |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| int_pad_o | output | 2 | Interrupt line levels, index 0 bank A |
| int_pad_oe | output | 2 | Interrupt line output enables |

## Verification
The assertions assume that each read strobe lasts exactly one clock, that a read strobe never coincides with a write, and that reset is held for at least one edge before any strobe. The bench drives every strobe from the falling edge for a single cycle and never overlaps reads with writes. It changes pins only on falling edges, so the synchronizer latency is a fixed count. Before each scenario it brings the block to a quiet state with all pins low and a clearing read, so that no leftover flag masks a new one.

// File: rtl/gpx_irq_unit.sv
module gpx_irq_unit #(
  parameter int BANK_W = 8,
  parameter int AW     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*BANK_W-1:0]   pin_i,
  input  logic [AW-1:0]         reg_addr,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [2*BANK_W-1:0]   reg_wdata,
  output logic [2*BANK_W-1:0]   reg_rdata,
  output logic [1:0]            int_pad_o,
  output logic [1:0]            int_pad_oe
);
  localparam int N = 2 * BANK_W;
  localparam logic [AW-1:0] A_EN   = AW'(2);
  localparam logic [AW-1:0] A_REF  = AW'(3);
  localparam logic [AW-1:0] A_MODE = AW'(4);
  localparam logic [AW-1:0] A_CFG  = AW'(5);
  localparam logic [AW-1:0] A_FLAG = AW'(7);
  localparam logic [AW-1:0] A_CAP  = AW'(8);
  localparam logic [AW-1:0] A_PORT = AW'(9);
  localparam int C_CC = 0, C_POL = 1, C_OD = 2, C_MIR = 6;

  logic [N-1:0] en_q, ref_q, mode_q, flag_q, cap_q;
  logic [7:0]   cfg_q;
  logic [N-1:0] s1_q, s2_q, prev_q;
  logic [N-1:0] hit, flag_nx, cap_nx;
  logic [1:0]   set_b, act, line;
  logic         clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; prev_q <= '0;
    end else begin
      s1_q <= pin_i; s2_q <= s1_q; prev_q <= s2_q;
    end
  end

  assign hit = en_q & ((mode_q & (s2_q ^ ref_q)) | (~mode_q & (s2_q ^ prev_q)));
  assign clr = reg_rd && (cfg_q[C_CC] ? (reg_addr == A_CAP) : (reg_addr == A_PORT));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [BANK_W-1:0] hb, pick;
    assign hb   = hit[b*BANK_W +: BANK_W];
    assign pick = hb & (~hb + 1'b1);
    assign set_b[b] = (flag_q[b*BANK_W +: BANK_W] == '0) && (|hb) && !clr;
    assign flag_nx[b*BANK_W +: BANK_W] = clr ? '0 :
                                         set_b[b] ? pick : flag_q[b*BANK_W +: BANK_W];
    assign cap_nx[b*BANK_W +: BANK_W]  = set_b[b] ? s2_q[b*BANK_W +: BANK_W]
                                                  : cap_q[b*BANK_W +: BANK_W];
    assign act[b] = |flag_q[b*BANK_W +: BANK_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0; cap_q <= '0;
    end else begin
      flag_q <= flag_nx; cap_q <= cap_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; ref_q <= '0; mode_q <= '0; cfg_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_EN:    en_q   <= reg_wdata;
        A_REF:   ref_q  <= reg_wdata;
        A_MODE:  mode_q <= reg_wdata;
        A_CFG:   cfg_q  <= reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_EN:    reg_rdata = en_q;
      A_REF:   reg_rdata = ref_q;
      A_MODE:  reg_rdata = mode_q;
      A_CFG:   reg_rdata = N'(cfg_q);
      A_FLAG:  reg_rdata = flag_q;
      A_CAP:   reg_rdata = cap_q;
      A_PORT:  reg_rdata = s2_q;
      default: reg_rdata = '0;
    endcase
  end

  assign line = cfg_q[C_MIR] ? {2{|act}} : act;
  assign int_pad_o  = cfg_q[C_OD] ? 2'b00 : (cfg_q[C_POL] ? line : ~line);
  assign int_pad_oe = cfg_q[C_OD] ? line : 2'b11;

  a_r4_onehot_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_q[BANK_W-1:0]) && $onehot0(flag_q[N-1:BANK_W]));

  a_r1_disabled_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(en_q)) == '0));

  a_r5_hold_bank_a: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flag_q[BANK_W-1:0]) && !clr) |=>
      ($stable(flag_q[BANK_W-1:0]) && $stable(cap_q[BANK_W-1:0])));

  a_r5_hold_bank_b: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flag_q[N-1:BANK_W]) && !clr) |=>
      ($stable(flag_q[N-1:BANK_W]) && $stable(cap_q[N-1:BANK_W])));

  a_r6_clear_read: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flag_q == '0));

  a_r9_never_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[C_OD] |-> ((int_pad_o & int_pad_oe) == 2'b00));
endmodule

// File: tb/tb_gpx_irq_unit.sv
module tb_gpx_irq_unit;
  localparam int PERIOD = 10;
  localparam logic [3:0] EN = 4'h2, REF = 4'h3, MODE = 4'h4, CFG = 4'h5,
                         FLAG = 4'h7, CAP = 4'h8, PORT = 4'h9;

  logic clk = 0, rst_n = 0;
  logic [15:0] pin_i = '0, reg_wdata = '0, reg_rdata;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  int_pad_o, int_pad_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  gpx_irq_unit dut (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_pad_o(int_pad_o), .int_pad_oe(int_pad_oe));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic peek(logic [3:0] a, output logic [15:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic quiet();
    logic [15:0] d;
    wr(CFG, 0); wr(EN, 0); wr(MODE, 0); wr(REF, 0);
    pin_i = '0; tick(4); rd(PORT, d);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    foreach (d[i]) ;
    for (int a = 0; a < 16; a++) begin
      peek(4'(a), d); chk("R11 reset read", d, 16'h0);
    end
    chk("R8 reset pad level", {14'h0, int_pad_o}, 16'h3);
    chk("R8 reset pad enable", {14'h0, int_pad_oe}, 16'h3);
  endtask

  task automatic t_disabled();
    logic [15:0] d;
    quiet();
    pin_i = 16'h00FF; tick(4);
    peek(FLAG, d); chk("R1 disabled pins", d, 16'h0);
    chk("R1 pads idle", {14'h0, int_pad_o}, 16'h3);
  endtask

  task automatic t_change();
    logic [15:0] d;
    quiet(); wr(EN, 16'hFFFF);
    pin_i = 16'h0008; tick(2);
    peek(FLAG, d); chk("R12 not before third edge", d, 16'h0);
    tick(1);
    peek(FLAG, d); chk("R12 R2 flag at third edge", d, 16'h0008);
    peek(CAP, d);  chk("R5 capture bank A", d & 16'h00FF, 16'h0008);
    chk("R8 active low line A", {14'h0, int_pad_o}, 16'h2);
    rd(CAP, d);
    peek(FLAG, d); chk("R6 capture read keeps flag", d, 16'h0008);
    rd(PORT, d);   chk("R6 port read data", d, 16'h0008);
    peek(FLAG, d); chk("R6 port read clears", d, 16'h0);
    chk("R6 pads idle after clear", {14'h0, int_pad_o}, 16'h3);
  endtask

  task automatic t_banks();
    logic [15:0] d;
    quiet(); wr(EN, 16'hFFFF);
    pin_i = 16'h1024; tick(4);
    peek(FLAG, d); chk("R4 lowest pin per bank", d, 16'h1004);
    peek(CAP, d);  chk("R5 capture both banks", d, 16'h1024);
    pin_i = 16'h1064; tick(4);
    peek(FLAG, d); chk("R5 flag held", d, 16'h1004);
    peek(CAP, d);  chk("R5 capture held", d, 16'h1024);
    rd(PORT, d); tick(2);
    peek(FLAG, d); chk("R6 cleared, no new change", d, 16'h0);
  endtask

  task automatic t_compare();
    logic [15:0] d;
    quiet(); wr(REF, 16'h0001); wr(MODE, 16'h0001); wr(EN, 16'h0001);
    tick(1);
    peek(FLAG, d); chk("R3 mismatch flags", d, 16'h0001);
    rd(PORT, d);
    peek(FLAG, d); chk("R3 cleared by read", d, 16'h0);
    tick(1);
    peek(FLAG, d); chk("R3 re-flags while mismatched", d, 16'h0001);
    pin_i = 16'h0001; tick(3); rd(PORT, d); tick(3);
    peek(FLAG, d); chk("R3 match stays clear", d, 16'h0);
  endtask

  task automatic t_capclear();
    logic [15:0] d;
    quiet(); wr(CFG, 16'h0001); wr(EN, 16'hFFFF);
    pin_i = 16'h0200; tick(4);
    rd(PORT, d);
    peek(FLAG, d); chk("R7 port read keeps flag", d, 16'h0200);
    rd(CAP, d);    chk("R7 capture data", d, 16'h0200);
    peek(FLAG, d); chk("R7 capture read clears", d, 16'h0);
  endtask

  task automatic t_polarity();
    logic [15:0] d;
    quiet(); wr(CFG, 16'h0002);
    chk("R8 active high idle", {14'h0, int_pad_o}, 16'h0);
    wr(EN, 16'hFFFF); pin_i = 16'h0002; tick(4);
    chk("R8 active high line A", {14'h0, int_pad_o}, 16'h1);
    chk("R8 driven", {14'h0, int_pad_oe}, 16'h3);
    peek(FLAG, d);
  endtask

  task automatic t_opendrain();
    quiet(); wr(CFG, 16'h0004);
    chk("R9 idle released", {14'h0, int_pad_oe}, 16'h0);
    wr(EN, 16'hFFFF); pin_i = 16'h0100; tick(4);
    chk("R9 bank B pulls low", {14'h0, int_pad_oe}, 16'h2);
    chk("R9 level low", {14'h0, int_pad_o}, 16'h0);
    wr(CFG, 16'h0006);
    chk("R9 polarity ignored", {14'h0, int_pad_o}, 16'h0);
    chk("R9 still pulls B", {14'h0, int_pad_oe}, 16'h2);
  endtask

  task automatic t_mirror();
    logic [15:0] d;
    quiet(); wr(CFG, 16'h0040); wr(EN, 16'hFFFF);
    pin_i = 16'h8000; tick(4);
    peek(FLAG, d); chk("R10 bank B flag only", d, 16'h8000);
    chk("R10 both lines active", {14'h0, int_pad_o}, 16'h0);
    wr(CFG, 16'h0000);
    chk("R10 unmirrored B only", {14'h0, int_pad_o}, 16'h1);
  endtask

  task automatic t_map();
    logic [15:0] d;
    quiet();
    wr(FLAG, 16'hFFFF); wr(CAP, 16'hFFFF); wr(PORT, 16'hFFFF);
    peek(FLAG, d); chk("R11 flag write ignored", d, 16'h0);
    peek(PORT, d); chk("R11 port write ignored", d, 16'h0);
    chk("R11 pads idle", {14'h0, int_pad_o}, 16'h3);
    wr(EN, 16'hA5C3); peek(EN, d); chk("R11 enable readback", d, 16'hA5C3);
    wr(CFG, 16'h0140); peek(CFG, d); chk("R11 config 8 bits", d, 16'h0040);
    peek(4'hF, d); chk("R11 unmapped reads 0", d, 16'h0);
    wr(CFG, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; tick(1);
    t_reset(); t_disabled(); t_change(); t_banks(); t_compare();
    t_capclear(); t_polarity(); t_opendrain(); t_mirror(); t_map();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule